// File: doc/BRIEF.md
# Burst Control Word Generator

The block builds the 16-bit control words that a packet transmitter inserts between bursts on a 64-bit data path. At each burst boundary slot it takes the markers from the packet source (start of packet, channel address, end of packet with its valid-byte code, and an abort flag) and packs them into one control word. The word carries an end-of-packet kind, a start-of-packet or new-burst flag with the channel address, or nothing at all (an idle word).

The generator keeps the channel address of the most recent burst. A burst that continues without a packet start gets an address-carrying word only when its channel differs from that tracked address. When a packet ends and the next one starts at the same boundary, both fields go into the same word. Outputs are registered, and a control qualifier marks the cycle that holds a control word. Alongside the word, the block gives the selected valid-byte code and a per-byte enable mask for the closing data beat.

Top module: `bcw_gen`

## Requirements
- R1: While rst_ni is low, ctl_o, word_o, mod_o and byte_en_o are all zero, and the tracked address is cleared.
- R2: ctl_o is high in the cycle after a cycle with boundary_i high, and low otherwise. When ctl_o is low, word_o, mod_o and byte_en_o are zero, and sop_i, burst_i, eop_i and err_i have no effect.
- R3: A boundary with burst_i and sop_i both high gives a word with bit 15 = 1, bit 12 = 1 and the channel address in bits 11:4.
- R4: A boundary with burst_i high, sop_i low and an address different from the tracked one gives bit 15 = 1, bit 12 = 0 and the address in bits 11:4.
- R5: A boundary with burst_i high, sop_i low and the tracked address leaves bits 15, 12 and 11:4 zero. The first burst after reset always counts as an address change.
- R6: Bits 14:13 hold the end kind: 10 for eop_i with odd_i low (even end), 11 for eop_i with odd_i high (odd end), and 00 when eop_i is low.
- R7: eop_i together with err_i forces bits 14:13 to 01, with mod_o = 000 and byte_en_o = 0, whatever odd_i and the modulus inputs are. err_i without eop_i has no effect.
- R8: An end of packet and a start (SOP or new burst) at the same boundary are packed into one word: the end kind goes in bits 14:13 and the start fields in bits 15, 12 and 11:4.
- R9: On an even end, mod_o equals mod_even_i. On an odd end, mod_o equals mod_odd_i. On any other word, mod_o is 000.
- R10: On an even or odd end, byte_en_o has its n top bits set, where n is the mod_o value and 000 means all 8 bytes. Bit 7 stands for data bits 63:56 and bit 0 for bits 7:0. Examples: 110 gives 0xFC, 001 gives 0x80.
- R11: A boundary with no burst and no end gives an idle word: ctl_o high and word_o = 0x0000. Bits 3:0 are always zero.
- R12: The tracked address changes only at a boundary with burst_i high. burst_i and addr_i on cycles without a boundary do not affect later new-burst decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | This cycle is a control-word slot |
| burst_i | input | 1 | A burst follows this slot |
| sop_i | input | 1 | The following burst starts a packet |
| addr_i | input | 8 | Channel address of the following burst |
| eop_i | input | 1 | The previous burst ended a packet |
| odd_i | input | 1 | The packet ended with an odd byte count |
| err_i | input | 1 | The packet ended with an abort |
| mod_even_i | input | 3 | Valid-byte code for an even end |
| mod_odd_i | input | 3 | Valid-byte code for an odd end |
| ctl_o | output | 1 | Control qualifier for word_o |
| word_o | output | 16 | Control word |
| mod_o | output | 3 | Selected valid-byte code |
| byte_en_o | output | 8 | Byte enables of the closing data beat |

## Verification
The assertions check every cycle that the qualifier follows the boundary slot by one cycle and that non-control cycles output zeros. They also check that a packet start always carries its address, that an abort overrides the end kind, that each end kind passes on the matching modulus input, and that the number of byte enables matches the modulus. Two kinds of behaviour depend on history, and only the bench scenarios show them. The first is the address tracking: repeated channels, a new channel, address changes outside a boundary, and the reset that makes the first burst a change. The second is the combined end-plus-start words.

// File: rtl/bcw_pkg.sv
package bcw_pkg;
  typedef enum logic [1:0] {
    END_NONE  = 2'b00,
    END_ABORT = 2'b01,
    END_EVEN  = 2'b10,
    END_ODD   = 2'b11
  } end_kind_e;

  localparam int unsigned WORD_W    = 16;
  localparam int unsigned START_BIT = 15;
  localparam int unsigned SOP_BIT   = 12;
  localparam int unsigned KIND_LSB  = 13;
  localparam int unsigned ADDR_LSB  = 4;
endpackage

// File: rtl/bcw_addr_track.sv
module bcw_addr_track #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              changed_o
);
  logic              have_q;
  logic [ADDR_W-1:0] last_q;

  // first burst after reset counts as a change
  assign changed_o = !have_q || (addr_i != last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= 1'b0;
      last_q <= '0;
    end else if (take_i) begin
      have_q <= 1'b1;
      last_q <= addr_i;
    end
  end
endmodule

// File: rtl/bcw_end_encode.sv
module bcw_end_encode
  import bcw_pkg::*;
#(
  parameter int unsigned LANES = 8,
  localparam int unsigned MOD_W = $clog2(LANES),
  localparam int unsigned CNT_W = MOD_W + 1
) (
  input  logic             eop_i,
  input  logic             odd_i,
  input  logic             err_i,
  input  logic [MOD_W-1:0] mod_even_i,
  input  logic [MOD_W-1:0] mod_odd_i,
  output end_kind_e        kind_o,
  output logic [MOD_W-1:0] mod_o,
  output logic [LANES-1:0] byte_en_o
);
  logic             normal;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    kind_o = END_NONE;
    mod_o  = '0;
    if (eop_i) begin
      if (err_i) begin
        kind_o = END_ABORT;
      end else if (odd_i) begin
        kind_o = END_ODD;
        mod_o  = mod_odd_i;
      end else begin
        kind_o = END_EVEN;
        mod_o  = mod_even_i;
      end
    end
  end

  assign normal = (kind_o == END_EVEN) || (kind_o == END_ODD);
  // code zero means a full beat
  assign cnt = (mod_o == '0) ? CNT_W'(LANES) : {1'b0, mod_o};

  // valid lanes are packed at the top of the beat
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign byte_en_o[g] = normal && ((32'(cnt) + 32'(g)) >= 32'(LANES));
  end
endmodule

// File: rtl/bcw_pack.sv
module bcw_pack
  import bcw_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 8,
  localparam int unsigned MOD_W    = $clog2(LANES),
  localparam int unsigned ADDR_MSB = ADDR_LSB + ADDR_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boundary_i,
  input  logic              burst_i,
  input  logic              sop_i,
  input  logic              changed_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  end_kind_e         kind_i,
  input  logic [MOD_W-1:0]  mod_i,
  input  logic [LANES-1:0]  byte_en_i,
  output logic              ctl_o,
  output logic [WORD_W-1:0] word_o,
  output logic [MOD_W-1:0]  mod_o,
  output logic [LANES-1:0]  byte_en_o
);
  logic [WORD_W-1:0] word_d;
  logic              start;

  assign start = burst_i && (sop_i || changed_i);

  always_comb begin
    word_d = '0;
    word_d[KIND_LSB +: 2] = kind_i;
    if (start) begin
      word_d[START_BIT]          = 1'b1;
      word_d[SOP_BIT]            = sop_i;
      word_d[ADDR_MSB:ADDR_LSB]  = addr_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_o     <= 1'b0;
      word_o    <= '0;
      mod_o     <= '0;
      byte_en_o <= '0;
    end else begin
      ctl_o     <= boundary_i;
      word_o    <= boundary_i ? word_d : '0;
      mod_o     <= boundary_i ? mod_i : '0;
      byte_en_o <= boundary_i ? byte_en_i : '0;
    end
  end
endmodule

// File: rtl/bcw_gen.sv
module bcw_gen
  import bcw_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 8,
  localparam int unsigned MOD_W = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boundary_i,
  input  logic              burst_i,
  input  logic              sop_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              eop_i,
  input  logic              odd_i,
  input  logic              err_i,
  input  logic [MOD_W-1:0]  mod_even_i,
  input  logic [MOD_W-1:0]  mod_odd_i,
  output logic              ctl_o,
  output logic [WORD_W-1:0] word_o,
  output logic [MOD_W-1:0]  mod_o,
  output logic [LANES-1:0]  byte_en_o
);
  logic             changed;
  end_kind_e        kind;
  logic [MOD_W-1:0] mod_sel;
  logic [LANES-1:0] byte_en;

  bcw_addr_track #(.ADDR_W(ADDR_W)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (boundary_i && burst_i),
    .addr_i    (addr_i),
    .changed_o (changed)
  );

  bcw_end_encode #(.LANES(LANES)) u_end (
    .eop_i      (eop_i),
    .odd_i      (odd_i),
    .err_i      (err_i),
    .mod_even_i (mod_even_i),
    .mod_odd_i  (mod_odd_i),
    .kind_o     (kind),
    .mod_o      (mod_sel),
    .byte_en_o  (byte_en)
  );

  bcw_pack #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .boundary_i (boundary_i),
    .burst_i    (burst_i),
    .sop_i      (sop_i),
    .changed_i  (changed),
    .addr_i     (addr_i),
    .kind_i     (kind),
    .mod_i      (mod_sel),
    .byte_en_i  (byte_en),
    .ctl_o      (ctl_o),
    .word_o     (word_o),
    .mod_o      (mod_o),
    .byte_en_o  (byte_en_o)
  );
endmodule

// File: rtl/bcw_gen_chk.sv
module bcw_gen_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 8,
  localparam int unsigned MOD_W = $clog2(LANES)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              boundary_i,
  input logic              burst_i,
  input logic              sop_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              eop_i,
  input logic              odd_i,
  input logic              err_i,
  input logic [MOD_W-1:0]  mod_even_i,
  input logic [MOD_W-1:0]  mod_odd_i,
  input logic              ctl_o,
  input logic [15:0]       word_o,
  input logic [MOD_W-1:0]  mod_o,
  input logic [LANES-1:0]  byte_en_o
);
  assert_ctl_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_i |=> ctl_o);
  assert_no_ctl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary_i |=> !ctl_o);
  assert_quiet_data_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_o |-> (word_o == '0 && mod_o == '0 && byte_en_o == '0));
  assert_sop_word_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && burst_i && sop_i) |=>
      (word_o[15] && word_o[12] && word_o[11:4] == $past(addr_i)));
  assert_abort_kind_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && eop_i && err_i) |=>
      (word_o[14:13] == 2'b01 && mod_o == '0 && byte_en_o == '0));
  assert_odd_mod_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && eop_i && !err_i && odd_i) |=> (mod_o == $past(mod_odd_i)));
  assert_even_mod_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && eop_i && !err_i && !odd_i) |=> (mod_o == $past(mod_even_i)));
  assert_lane_count_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_o && word_o[14]) |->
      ($countones(byte_en_o) == ((mod_o == '0) ? LANES : int'(mod_o)) && byte_en_o[LANES-1]));
endmodule

bind bcw_gen bcw_gen_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (.*);

// File: tb/bcw_gen_tb.sv
`timescale 1ns/1ps
module bcw_gen_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       boundary = 0, burst = 0, sop = 0, eop = 0, odd = 0, err = 0;
  logic [7:0] addr = '0;
  logic [2:0] mod_even = '0, mod_odd = '0;
  logic       ctl;
  logic [15:0] word;
  logic [2:0] mod;
  logic [7:0] be;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic        ctl;
    logic [15:0] word;
    logic [2:0]  mod;
    logic [7:0]  be;
    string       tag;
  } exp_t;
  exp_t q[$];

  bit         m_have = 0;
  logic [7:0] m_last = '0;

  always #2 clk = ~clk;

  bcw_gen u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .boundary_i(boundary), .burst_i(burst),
    .sop_i(sop), .addr_i(addr), .eop_i(eop), .odd_i(odd), .err_i(err),
    .mod_even_i(mod_even), .mod_odd_i(mod_odd),
    .ctl_o(ctl), .word_o(word), .mod_o(mod), .byte_en_o(be)
  );

  task automatic drive(input string tag, input bit b, input bit bu, input bit s,
                       input logic [7:0] a, input bit e, input bit o, input bit er,
                       input logic [2:0] me, input logic [2:0] mo);
    exp_t x;
    int n;
    @(negedge clk);
    boundary = b; burst = bu; sop = s; addr = a; eop = e; odd = o; err = er;
    mod_even = me; mod_odd = mo;
    x.ctl = b; x.word = '0; x.mod = '0; x.be = '0; x.tag = tag;
    if (b) begin
      if (bu) begin
        if (s) begin
          x.word[15] = 1; x.word[12] = 1; x.word[11:4] = a;
        end else if (!m_have || a != m_last) begin
          x.word[15] = 1; x.word[11:4] = a;
        end
        m_have = 1; m_last = a;
      end
      if (e) begin
        if (er) x.word[14:13] = 2'b01;
        else begin
          x.word[14:13] = o ? 2'b11 : 2'b10;
          x.mod = o ? mo : me;
          n = (x.mod == 0) ? 8 : int'(x.mod);
          x.be = ~(8'hff >> n);
        end
      end
    end
    q.push_back(x);
  endtask

  task automatic idle(input string tag, input int cycles);
    for (int i = 0; i < cycles; i++) drive(tag, 0, 0, 0, 8'h00, 0, 0, 0, 3'd0, 3'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0;
    boundary = 0; burst = 0; sop = 0; eop = 0; odd = 0; err = 0;
    m_have = 0; m_last = '0;
    @(negedge clk);
    total++;
    if (ctl !== 0 || word !== 0 || mod !== 0 || be !== 0) begin
      bad++;
      $display("FAIL R1: ctl=%b word=%h mod=%h be=%h expected all zero", ctl, word, mod, be);
    end
    @(negedge clk);
    rst_ni = 1;
  endtask

  initial begin : monitor
    exp_t x;
    forever begin
      @(posedge clk);
      #1;
      if (rst_ni && q.size() > 0) begin
        x = q.pop_front();
        total++;
        if (ctl !== x.ctl || word !== x.word || mod !== x.mod || be !== x.be) begin
          bad++;
          $display("FAIL %s: ctl=%b word=%h mod=%h be=%h expected ctl=%b word=%h mod=%h be=%h",
                   x.tag, ctl, word, mod, be, x.ctl, x.word, x.mod, x.be);
        end
      end
    end
  end

  initial begin : watchdog
    #200000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    do_reset();
    idle("R2", 2);
    drive("R11", 1, 0, 0, 8'h00, 0, 0, 0, 3'd0, 3'd0);
    drive("R3", 1, 1, 1, 8'h5A, 0, 0, 0, 3'd0, 3'd0);
    drive("R2", 0, 1, 1, 8'h5A, 1, 0, 1, 3'd6, 3'd5);   // markers outside a slot
    drive("R5", 1, 1, 0, 8'h5A, 0, 0, 0, 3'd0, 3'd0);
    drive("R4", 1, 1, 0, 8'h33, 0, 0, 0, 3'd0, 3'd0);
    drive("R6", 1, 0, 0, 8'h00, 1, 0, 0, 3'b110, 3'b111);
    drive("R9", 1, 0, 0, 8'h00, 1, 1, 0, 3'b000, 3'b101);
    drive("R10", 1, 0, 0, 8'h00, 1, 0, 0, 3'b000, 3'b001);
    drive("R10", 1, 0, 0, 8'h00, 1, 1, 0, 3'b110, 3'b001);
    drive("R10", 1, 0, 0, 8'h00, 1, 0, 0, 3'b010, 3'b011);
    drive("R7", 1, 0, 0, 8'h00, 1, 1, 1, 3'b110, 3'b011);
    drive("R7", 1, 1, 1, 8'h11, 0, 1, 1, 3'b100, 3'b011);
    drive("R8", 1, 1, 1, 8'h22, 1, 0, 0, 3'b100, 3'b001);
    drive("R8", 1, 1, 0, 8'h44, 1, 1, 0, 3'b000, 3'b111);
    drive("R12", 0, 1, 0, 8'h77, 0, 0, 0, 3'd0, 3'd0);
    drive("R12", 1, 1, 0, 8'h44, 0, 0, 0, 3'd0, 3'd0);
    drive("R12", 1, 1, 0, 8'h77, 1, 0, 1, 3'd0, 3'd0);
    drive("R11", 1, 0, 1, 8'h99, 0, 1, 1, 3'd7, 3'd7);
    idle("R2", 3);
    do_reset();
    drive("R5", 1, 1, 0, 8'h77, 0, 0, 0, 3'd0, 3'd0);  // first burst after reset
    drive("R5", 1, 1, 0, 8'h77, 1, 0, 0, 3'b100, 3'd0);
    idle("R2", 3);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule